// File: doc/BRIEF.md
# Timer Unit Register Decoder

This block is the register-side front end of a timer unit that holds two or three counting channels. A host issues single-cycle accesses into a small flat offset space. The block decodes each offset into one of four targets: a shared pin-mode register, a shared run register, the register window of one channel, or a rejected access. Accepted channel accesses go out on a shared channel bus. The bus carries a one-hot select and the offset relative to the window base. The counting logic inside the channels is not part of this block.

Bits of the run register drive each channel's run enable directly. Build-time parameters set whether the third channel exists and whether the pin-mode register exists. Accesses that reach a missing resource are rejected with a one-cycle error response and have no effect. The block also fans out per-channel feature flags: capture is enabled only on the third channel, and every channel gets the same external-clock flag. It passes each channel's interrupt line to a per-channel interrupt vector.

Top module: `tmr_fe_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_valid`, `rsp_err`, `ch_sel`, `ch_run` and `tclk_drive` are all 0.
- R2: An aligned access in a channel window asserts bit n of `ch_sel` in the same cycle and places the offset minus the window base on `ch_off`. The window bases are 0x08, 0x14 and 0x20. Windows 0 and 1 span 12 bytes. Window 2 spans 16 bytes, and its extra word at relative offset 0x0C is the capture register. `acc_write` and `acc_wdata` are forwarded unchanged.
- R3: A legal write to offset 0x04 stores write-data bits [NCH-1:0] into the run register, and `ch_run` shows them from the next cycle. Bits above them are ignored. A read of 0x04 returns the stored bits zero-extended.
- R4: When the pin-mode register is present, a write to offset 0x00 stores bit 0 and drives it on `tclk_drive` from the next cycle. A read returns that bit zero-extended.
- R5: When the pin-mode register is absent, any access to offset 0x00 is an error, and `tclk_drive` stays 0.
- R6: When only two channels exist, any access at offset 0x20 or above is an error and selects no channel.
- R7: When only two channels exist, a write to 0x04 with data bit 2 set is an error, and the run register keeps its value.
- R8: An erroneous access gives `rsp_err`=1 for exactly one cycle with `rsp_rdata`=0, selects no channel and changes no register.
- R9: An offset with nonzero bits [1:0], and any offset past the last window, is an error.
- R10: `ch_cap_en` is set only for channel index 2. Every bit of `ch_extclk` equals the external-clock parameter.
- R11: `irq_vec` equals `ch_irq` bit for bit, with no delay.
- R12: `rsp_valid` is high in the cycle after each access and low otherwise. On a legal read, `rsp_rdata` then holds the data addressed in the access cycle; on a write it holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset into the unit |
| acc_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Previous access was rejected |
| rsp_rdata | output | DATA_W | Read data of the previous access |
| ch_sel | output | NCH | One-hot channel select |
| ch_write | output | 1 | Forwarded write strobe qualifier |
| ch_off | output | 4 | Offset within the selected window |
| ch_wdata | output | DATA_W | Forwarded write data |
| ch_rdata | input | NCH*DATA_W | Read data from each channel, channel 0 lowest |
| ch_run | output | NCH | Per-channel run enable |
| ch_cap_en | output | NCH | Per-channel capture feature flag |
| ch_extclk | output | NCH | Per-channel external-clock feature flag |
| ch_irq | input | NCH | Per-channel interrupt lines |
| irq_vec | output | NCH | Combined interrupt vector |
| tclk_drive | output | 1 | Stored pin-mode bit |

## Verification
Two copies of the block run side by side on the same stimulus: a full build with three channels and the pin-mode register, and a reduced build with neither. Every offset therefore shows both its accepting and its rejecting behaviour. Run-register writes use data with bit 2 set and junk upper bits. This separates correct masking from a full-byte store, and it separates the reduced build's error path from a silent truncation. Reads sweep every word of every window, including the capture word. This exposes a wrong base, a wrong subtraction or an off-by-one window edge. Misaligned and out-of-range offsets confirm that nothing is selected and nothing changes.

// File: rtl/tmr_fe_pkg.sv
package tmr_fe_pkg;

    localparam int unsigned MAX_CH       = 3;
    localparam int unsigned CH_OFF_W     = 4;
    localparam int unsigned PINMODE_OFS  = 32'h00;
    localparam int unsigned RUN_OFS      = 32'h04;
    localparam int unsigned WIN_BASE     = 32'h08;
    localparam int unsigned WIN_STRIDE   = 12;
    localparam int unsigned WIN_SPAN     = 12;
    localparam int unsigned WIN_SPAN_CAP = 16;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_PINMODE,
        RG_RUN,
        RG_CHAN
    } region_e;

    typedef struct packed {
        region_e               region;
        logic [1:0]            chan;
        logic [CH_OFF_W-1:0]   off;
    } dec_t;

    // Map a byte offset onto a target; absent resources decode to RG_NONE.
    function automatic dec_t decode_ofs(input logic [31:0] ofs,
                                        input int unsigned nch,
                                        input bit has_pinmode);
        dec_t d;
        d.region = RG_NONE;
        d.chan   = '0;
        d.off    = '0;
        if (ofs[1:0] == 2'b00) begin
            if (ofs == PINMODE_OFS && has_pinmode) begin
                d.region = RG_PINMODE;
            end else if (ofs == RUN_OFS) begin
                d.region = RG_RUN;
            end else begin
                for (int n = 0; n < MAX_CH; n++) begin
                    int unsigned base;
                    int unsigned span;
                    logic [31:0] rel;
                    base = WIN_BASE + n * WIN_STRIDE;
                    span = (n == MAX_CH - 1) ? WIN_SPAN_CAP : WIN_SPAN;
                    rel  = ofs - base;
                    if (n < nch && ofs >= base && ofs < base + span) begin
                        d.region = RG_CHAN;
                        d.chan   = 2'(n);
                        d.off    = rel[CH_OFF_W-1:0];
                    end
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/tmr_fe_decode.sv
module tmr_fe_decode
    import tmr_fe_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NCH         = 3,
    parameter int HAS_PINMODE = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              run_b2,
    output dec_t              dec,
    output logic              bad
);
    always_comb begin
        dec = decode_ofs(32'(addr), NCH, HAS_PINMODE != 0);
        bad = (dec.region == RG_NONE);
        if (write && dec.region == RG_RUN && NCH < MAX_CH && run_b2)
            bad = 1'b1;
    end
endmodule

// File: rtl/tmr_fe_ctl_regs.sv
module tmr_fe_ctl_regs #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run_we,
    input  logic           pin_we,
    input  logic [NCH-1:0] wbits,
    output logic [NCH-1:0] run,
    output logic           pin
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
            pin <= 1'b0;
        end else begin
            if (run_we) run <= wbits;
            if (pin_we) pin <= wbits[0];
        end
    end
endmodule

// File: rtl/tmr_fe_rsp.sv
module tmr_fe_rsp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              bad,
    input  logic [DATA_W-1:0] rd,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_err   <= acc_valid && bad;
            rsp_rdata <= (acc_valid && !bad && !acc_write) ? rd : '0;
        end
    end
endmodule

// File: rtl/tmr_fe_top.sv
module tmr_fe_top
    import tmr_fe_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int HAS_THIRD   = 1,
    parameter int HAS_PINMODE = 1,
    parameter int EXT_CLK     = 1,
    localparam int NCH        = (HAS_THIRD != 0) ? 3 : 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [DATA_W-1:0]     acc_wdata,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [NCH-1:0]        ch_sel,
    output logic                  ch_write,
    output logic [CH_OFF_W-1:0]   ch_off,
    output logic [DATA_W-1:0]     ch_wdata,
    input  logic [NCH*DATA_W-1:0] ch_rdata,
    output logic [NCH-1:0]        ch_run,
    output logic [NCH-1:0]        ch_cap_en,
    output logic [NCH-1:0]        ch_extclk,
    input  logic [NCH-1:0]        ch_irq,
    output logic [NCH-1:0]        irq_vec,
    output logic                  tclk_drive
);
    dec_t              dec;
    logic              bad;
    logic              ok;
    logic [DATA_W-1:0] rd;

    tmr_fe_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .HAS_PINMODE(HAS_PINMODE)) u_dec (
        .addr   (acc_addr),
        .write  (acc_write),
        .run_b2 (acc_wdata[2]),
        .dec    (dec),
        .bad    (bad)
    );

    assign ok = acc_valid && !bad;

    tmr_fe_ctl_regs #(.NCH(NCH)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .run_we (ok && acc_write && dec.region == RG_RUN),
        .pin_we (ok && acc_write && dec.region == RG_PINMODE),
        .wbits  (acc_wdata[NCH-1:0]),
        .run    (ch_run),
        .pin    (tclk_drive)
    );

    // Per-channel select and fixed feature flags.
    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign ch_sel[n]    = ok && dec.region == RG_CHAN && dec.chan == 2'(n);
        assign ch_cap_en[n] = (n == MAX_CH - 1);
        assign ch_extclk[n] = (EXT_CLK != 0);
    end

    assign ch_write = acc_write;
    assign ch_off   = dec.off;
    assign ch_wdata = acc_wdata;
    assign irq_vec  = ch_irq;

    always_comb begin
        rd = '0;
        unique case (dec.region)
            RG_PINMODE: rd[0] = tclk_drive;
            RG_RUN:     rd[NCH-1:0] = ch_run;
            RG_CHAN: begin
                for (int n = 0; n < NCH; n++)
                    if (dec.chan == 2'(n)) rd = ch_rdata[n*DATA_W +: DATA_W];
            end
            default:    rd = '0;
        endcase
    end

    tmr_fe_rsp #(.DATA_W(DATA_W)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .bad       (bad),
        .rd        (rd),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/tmr_fe_chk.sv
module tmr_fe_chk #(
    parameter int NCH    = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [NCH-1:0]    ch_sel,
    input logic [NCH-1:0]    ch_run,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata
);
    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_sel));

    // R12
    rsp_follows_acc_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(acc_valid));

    // R8
    err_has_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    // R8
    sel_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_sel != '0) |=> !rsp_err);

    // R3
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write) |=> $stable(ch_run));
endmodule

bind tmr_fe_top tmr_fe_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .ch_sel    (ch_sel),
    .ch_run    (ch_run),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
);

// File: tb/tmr_fe_top_bench.sv
module tmr_fe_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;

    logic        f_rv, f_re, f_cw, f_tclk;
    logic [31:0] f_rd, f_cwd;
    logic [2:0]  f_sel, f_run, f_cap, f_ext, f_irq, f_iv;
    logic [3:0]  f_off;
    logic [95:0] f_crd;

    logic        l_rv, l_re, l_cw, l_tclk;
    logic [31:0] l_rd, l_cwd;
    logic [1:0]  l_sel, l_run, l_cap, l_ext, l_irq, l_iv;
    logic [3:0]  l_off;
    logic [63:0] l_crd;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    int m_run_f = 0, m_pin_f = 0, m_run_l = 0;

    always #10 clk = ~clk;

    tmr_fe_top u_tmr_fe_top (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rsp_valid(f_rv), .rsp_err(f_re), .rsp_rdata(f_rd),
        .ch_sel(f_sel), .ch_write(f_cw), .ch_off(f_off), .ch_wdata(f_cwd),
        .ch_rdata(f_crd), .ch_run(f_run), .ch_cap_en(f_cap), .ch_extclk(f_ext),
        .ch_irq(f_irq), .irq_vec(f_iv), .tclk_drive(f_tclk)
    );

    tmr_fe_top #(.HAS_THIRD(0), .HAS_PINMODE(0), .EXT_CLK(0)) u_tmr_fe_top_lite (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rsp_valid(l_rv), .rsp_err(l_re), .rsp_rdata(l_rd),
        .ch_sel(l_sel), .ch_write(l_cw), .ch_off(l_off), .ch_wdata(l_cwd),
        .ch_rdata(l_crd), .ch_run(l_run), .ch_cap_en(l_cap), .ch_extclk(l_ext),
        .ch_irq(l_irq), .irq_vec(l_iv), .tclk_drive(l_tclk)
    );

    // Channel models: each returns a tag plus the relative offset it sees.
    always_comb begin
        for (int n = 0; n < 3; n++)
            f_crd[n*32 +: 32] = 32'hA000_0000 | (32'(n) << 16) | 32'(f_off);
        for (int n = 0; n < 2; n++)
            l_crd[n*32 +: 32] = 32'hA000_0000 | (32'(n) << 16) | 32'(l_off);
    end

    function automatic int win_base(int n);
        return 8 + 12 * n;
    endfunction

    function automatic int exp_chan(int addr, int nch);
        for (int n = 0; n < nch; n++) begin
            int span;
            span = (n == 2) ? 16 : 12;
            if (addr >= win_base(n) && addr < win_base(n) + span) return n;
        end
        return -1;
    endfunction

    function automatic bit exp_err(bit wr, int addr, int data, int nch, bit pin);
        if (addr % 4 != 0) return 1;
        if (addr == 0) return !pin;
        if (addr == 4) return (wr && nch == 2 && data[2]);
        return exp_chan(addr, nch) < 0;
    endfunction

    function automatic int exp_rd(bit wr, int addr, int nch, bit pin, int run, int pv);
        int c;
        if (wr || exp_err(wr, addr, 0, nch, pin)) return 0;
        if (addr == 0) return pv;
        if (addr == 4) return run;
        c = exp_chan(addr, nch);
        return 32'hA000_0000 | (c << 16) | (addr - win_base(c));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(string tag, bit wr, int addr, int data);
        bit ef, el;
        int cf, cl, rf, rl;
        acc_valid = 1'b1; acc_write = wr; acc_addr = 8'(addr); acc_wdata = data;
        #1;
        ef = exp_err(wr, addr, data, 3, 1);
        el = exp_err(wr, addr, data, 2, 0);
        cf = exp_chan(addr, 3);
        cl = exp_chan(addr, 2);
        chk({tag, " R2 full ch_sel"}, 32'(f_sel), (!ef && cf >= 0) ? (1 << cf) : 0);
        chk({tag, " R2 lite ch_sel"}, 32'(l_sel), (!el && cl >= 0) ? (1 << cl) : 0);
        if (!ef && cf >= 0) begin
            chk({tag, " R2 full ch_off"}, 32'(f_off), addr - win_base(cf));
            chk({tag, " R2 full ch_wdata"}, f_cwd, data);
            chk({tag, " R2 full ch_write"}, 32'(f_cw), 32'(wr));
        end
        if (!el && cl >= 0)
            chk({tag, " R2 lite ch_off"}, 32'(l_off), addr - win_base(cl));
        rf = exp_rd(wr, addr, 3, 1, m_run_f, m_pin_f);
        rl = exp_rd(wr, addr, 2, 0, m_run_l, 0);
        @(negedge clk);
        acc_valid = 1'b0;
        chk({tag, " R12 full rsp_valid"}, 32'(f_rv), 1);
        chk({tag, " R12 lite rsp_valid"}, 32'(l_rv), 1);
        chk({tag, " R8 full rsp_err"}, 32'(f_re), 32'(ef));
        chk({tag, " R8 lite rsp_err"}, 32'(l_re), 32'(el));
        chk({tag, " full rdata"}, f_rd, rf);
        chk({tag, " lite rdata"}, l_rd, rl);
        if (wr && !ef && addr == 4) m_run_f = data & 7;
        if (wr && !ef && addr == 0) m_pin_f = data & 1;
        if (wr && !el && addr == 4) m_run_l = data & 3;
        chk({tag, " R3 full ch_run"}, 32'(f_run), m_run_f);
        chk({tag, " R3 lite ch_run"}, 32'(l_run), m_run_l);
        chk({tag, " R4 full tclk"}, 32'(f_tclk), m_pin_f);
        chk({tag, " R5 lite tclk"}, 32'(l_tclk), 0);
    endtask

    task automatic idle();
        @(negedge clk);
        chk("R12 idle full rsp_valid", 32'(f_rv), 0);
        chk("R12 idle lite rsp_valid", 32'(l_rv), 0);
        chk("R3 idle full ch_run", 32'(f_run), m_run_f);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        f_irq = '0; l_irq = '0;
        repeat (3) @(negedge clk);
        chk("R1 full rsp_valid", 32'(f_rv), 0);
        chk("R1 full rsp_err", 32'(f_re), 0);
        chk("R1 full ch_run", 32'(f_run), 0);
        chk("R1 lite ch_run", 32'(l_run), 0);
        chk("R1 full tclk", 32'(f_tclk), 0);
        chk("R1 full ch_sel", 32'(f_sel), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset rsp_valid", 32'(f_rv), 0);

        // R10 feature flags
        chk("R10 full cap_en", 32'(f_cap), 3'b100);
        chk("R10 lite cap_en", 32'(l_cap), 0);
        chk("R10 full extclk", 32'(f_ext), 3'b111);
        chk("R10 lite extclk", 32'(l_ext), 0);

        // R11 interrupt pass-through
        f_irq = 3'b101; l_irq = 2'b10; #1;
        chk("R11 full irq_vec", 32'(f_iv), 3'b101);
        chk("R11 lite irq_vec", 32'(l_iv), 2'b10);
        f_irq = 3'b010; l_irq = 2'b01; #1;
        chk("R11 full irq_vec b", 32'(f_iv), 3'b010);
        chk("R11 lite irq_vec b", 32'(l_iv), 2'b01);

        // R3 / R7 run register
        access("R7 run write bit2", 1, 4, 32'hFFFF_FFF5);
        access("R3 run read", 0, 4, 0);
        access("R3 run write low", 1, 4, 32'h0000_0F02);
        access("R3 run read b", 0, 4, 0);
        access("R7 run write bit2 again", 1, 4, 32'h0000_0007);
        idle();
        access("R3 run clear", 1, 4, 0);

        // R4 / R5 pin-mode register
        access("R4 R5 pin write", 1, 0, 32'h0000_00FF);
        access("R4 R5 pin read", 0, 0, 0);
        access("R4 pin clear", 1, 0, 32'h0000_0002);
        access("R4 pin read b", 0, 0, 0);

        // R2 / R6 window sweep, including the capture word
        for (int a = 8; a < 48; a += 4)
            access("R2 R6 window read", 0, a, 0);
        access("R2 write ch1", 1, 32'h18, 32'h1234_5678);
        access("R6 write ch2", 1, 32'h2C, 32'hCAFE_F00D);

        // R9 misaligned and out-of-range offsets
        access("R9 misaligned", 0, 32'h09, 0);
        access("R9 misaligned write", 1, 32'h06, 32'h7);
        access("R9 past map", 0, 32'h30, 0);
        access("R9 far past map", 1, 32'hFC, 32'h1);
        idle();
        idle();

        summary();
        $finish;
    end
endmodule